// File: doc/BRIEF.md
# Byte Write Enable Decoder

This block turns the write controls of a 32-bit synchronous memory word into a registered per-byte write mask and a flag that reports a write. The controls are a global write strobe, a byte-write qualifier and one select per byte lane. All of them are active low and are sampled on the rising clock. The global strobe forces every lane to be written. When the global strobe is inactive, each lane's select takes effect only while the byte-write qualifier is low.

The same clock edge also applies the decoded mask to a lane-merge register that holds one word. Enabled lanes take the incoming write data. Every other lane keeps its stored byte. The merged word is an output, so the effect of each write can be seen lane by lane. Lane and width counts are parameters, with the defaults set to four 8-bit lanes.

Top module: `byte_write_decoder`

## Requirements
- R1: While `rst_n` is low, `wr_mask`, `wr_seen` and `word_q` are all zero.
- R2: When `gw_n` is low at a rising edge, `wr_mask` becomes all ones after that edge, whatever `bwe_n` and `bsel_n` are.
- R3: When `gw_n` is high and `bwe_n` is low at a rising edge, `wr_mask[i]` becomes the inverse of `bsel_n[i]`. Bit 0 is lane A, which is data bits 7:0. Bit 1 is lane B (15:8), bit 2 is lane C (23:16) and bit 3 is lane D (31:24).
- R4: When `gw_n` and `bwe_n` are both high at a rising edge, `wr_mask` becomes zero and `wr_seen` becomes low.
- R5: When `bwe_n` is low, `gw_n` is high and every bit of `bsel_n` is high, `wr_mask` becomes zero and `wr_seen` becomes low.
- R6: `wr_seen` is high exactly when the registered mask enables at least one lane, so a write covers one to four bytes.
- R7: At each rising edge, a lane of `word_q` whose mask bit is being set loads the matching byte of `wdata`. Every other lane keeps its previous contents.
- R8: The outputs change only at a rising edge, one clock after the inputs are sampled. A change on an input between edges leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low, bit 0 = lane A |
| wdata | input | 32 | Write data, lane i on bits 8i+7:8i |
| wr_mask | output | 4 | Registered byte write mask |
| wr_seen | output | 1 | Registered write-detected flag |
| word_q | output | 32 | Lane-merge register contents |

## Verification
The bench sweeps all 64 combinations of the six control inputs and compares each result with a mask computed from the rules. The sweep therefore catches three kinds of fault:
- a global strobe that fails to override a qualifier held high;
- selects that act without the qualifier;
- a lane order that is swapped, which shows up as the wrong byte of the merged word changing.

The qualifier-low, all-selects-high case is checked on its own, because a design that derives the flag from the qualifier alone would report a write there. A mid-cycle input change is checked before the next edge, which exposes any combinational path from the inputs to the outputs.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
   typedef enum logic [1:0] {
      WK_NONE  = 2'd0,
      WK_BYTES = 2'd1,
      WK_ALL   = 2'd2
   } wr_kind_t;
endpackage

// File: rtl/bwd_decode.sv
module bwd_decode
   import bwd_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   output logic [LANES-1:0] mask,
   output wr_kind_t         kind
);
   always_comb begin
      if (!gw_n) begin
         mask = '1;
         kind = WK_ALL;
      end else if (!bwe_n) begin
         mask = ~bsel_n;
         kind = (&bsel_n) ? WK_NONE : WK_BYTES;
      end else begin
         mask = '0;
         kind = WK_NONE;
      end
   end
endmodule

// File: rtl/bwd_ctrl_reg.sv
module bwd_ctrl_reg
   import bwd_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   input  logic [LANES-1:0] mask_d,
   input  wr_kind_t         kind_d,
   output logic [LANES-1:0] mask_q,
   output logic             seen_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         seen_q <= 1'b0;
      end else begin
         mask_q <= mask_d;
         seen_q <= (kind_d != WK_NONE);
      end
   end

   // R2
   global_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gw_n |=> (&mask_q));
   // R3
   byte_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_n && !bwe_n) |=> (mask_q == ~$past(bsel_n)));
   // R4
   no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_n && bwe_n) |=> (mask_q == '0 && !seen_q));
   // R6
   seen_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q == (|mask_q));
endmodule

// File: rtl/bwd_lane.sv
module bwd_lane #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LANE_W-1:0] d,
   output logic [LANE_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   // R7
   lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
   // R7
   lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(d)));
endmodule

// File: rtl/byte_write_decoder.sv
module byte_write_decoder
   import bwd_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bsel_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES-1:0]        wr_mask,
   output logic                    wr_seen,
   output logic [LANES*LANE_W-1:0] word_q
);
   localparam int WORD_W = LANES * LANE_W;

   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("byte_write_decoder: LANES out of range");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("byte_write_decoder: LANE_W must be positive");
   end

   logic [LANES-1:0] dec_mask;
   wr_kind_t         dec_kind;

   bwd_decode #(.LANES(LANES)) i_decode (
      .gw_n   (gw_n),
      .bwe_n  (bwe_n),
      .bsel_n (bsel_n),
      .mask   (dec_mask),
      .kind   (dec_kind)
   );

   bwd_ctrl_reg #(.LANES(LANES)) i_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .gw_n   (gw_n),
      .bwe_n  (bwe_n),
      .bsel_n (bsel_n),
      .mask_d (dec_mask),
      .kind_d (dec_kind),
      .mask_q (wr_mask),
      .seen_q (wr_seen)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      bwd_lane #(.LANE_W(LANE_W)) i_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (dec_mask[i]),
         .d     (wdata[i*LANE_W +: LANE_W]),
         .q     (word_q[i*LANE_W +: LANE_W])
      );
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (wr_mask == '0 && !wr_seen && word_q == '0));
   // R5
   empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_n && !bwe_n && (&bsel_n)) |=> (!wr_seen && wr_mask == '0));
   // R6
   lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_seen |-> ($countones(wr_mask) >= 1 && $countones(wr_mask) <= LANES));

   logic unused_w;
   assign unused_w = ^WORD_W[0];
endmodule

// File: tb/test_byte_write_decoder.sv
module test_byte_write_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gw_n = 1'b1;
   logic        bwe_n = 1'b1;
   logic [3:0]  bsel_n = 4'hF;
   logic [31:0] wdata = '0;
   logic [3:0]  wr_mask;
   logic        wr_seen;
   logic [31:0] word_q;

   int checks = 0;
   int errors = 0;
   logic [31:0] model = '0;

   always #10 clk = ~clk;

   byte_write_decoder i_byte_write_decoder (
      .clk(clk), .rst_n(rst_n), .gw_n(gw_n), .bwe_n(bwe_n),
      .bsel_n(bsel_n), .wdata(wdata),
      .wr_mask(wr_mask), .wr_seen(wr_seen), .word_q(word_q)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_mask(logic g, logic b, logic [3:0] s);
      if (!g)      return 4'hF;
      else if (!b) return ~s;
      else         return 4'h0;
   endfunction

   task automatic apply(logic g, logic b, logic [3:0] s, logic [31:0] d);
      @(negedge clk);
      gw_n = g; bwe_n = b; bsel_n = s; wdata = d;
      @(negedge clk);
   endtask

   task automatic expect_cycle(string req, logic g, logic b, logic [3:0] s,
                               logic [31:0] d);
      logic [3:0] m;
      m = ref_mask(g, b, s);
      for (int i = 0; i < 4; i++)
         if (m[i]) model[i*8 +: 8] = d[i*8 +: 8];
      apply(g, b, s, d);
      check({req, " mask"}, {28'h0, wr_mask}, {28'h0, m});
      check("R6 seen", {31'h0, wr_seen}, {31'h0, (m != 0)});
      check("R7 word", word_q, model);
   endtask

   task automatic t_reset();
      #3;
      check("R1 mask", {28'h0, wr_mask}, 32'h0);
      check("R1 seen", {31'h0, wr_seen}, 32'h0);
      check("R1 word", word_q, 32'h0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_sweep();
      for (int c = 0; c < 64; c++) begin
         logic g, b;
         logic [3:0] s;
         g = c[5]; b = c[4]; s = c[3:0];
         expect_cycle(!g ? "R2" : (b ? "R4" : (&s ? "R5" : "R3")),
                      g, b, s, 32'h01020304 * (c + 1) ^ {c[7:0], 24'h5A3C96});
      end
   endtask

   task automatic t_lanes();
      expect_cycle("R2", 1'b0, 1'b1, 4'h0, 32'h00000000);
      expect_cycle("R3 laneA", 1'b1, 1'b0, 4'b1110, 32'hFFFFFF11);
      expect_cycle("R3 laneD", 1'b1, 1'b0, 4'b0111, 32'h44FFFFFF);
      expect_cycle("R3 laneB", 1'b1, 1'b0, 4'b1101, 32'hFFFF22FF);
      expect_cycle("R3 laneC", 1'b1, 1'b0, 4'b1011, 32'hFF33FFFF);
      check("R7 order", word_q, 32'h44332211);
      expect_cycle("R5", 1'b1, 1'b0, 4'hF, 32'hDEADBEEF);
      expect_cycle("R4", 1'b1, 1'b1, 4'h0, 32'hCAFEF00D);
      check("R7 kept", word_q, 32'h44332211);
   endtask

   task automatic t_hold();
      @(negedge clk);
      gw_n = 1'b0; wdata = 32'h99887766;
      #2;
      check("R8 mask", {28'h0, wr_mask}, 32'h0);
      check("R8 word", word_q, model);
      @(negedge clk);
      model = 32'h99887766;
      check("R8 after", word_q, model);
      gw_n = 1'b1;
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_sweep();
            t_lanes();
            t_hold();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule